// File: doc/BRIEF.md
# Multi-channel delay pulse sequencer

This block produces one timing cycle each time it accepts a start strobe. All timing comes from counting periods of the system clock, with one tick being 10 ns at 100 MHz. A reference output rises a fixed latency after the accepted start and marks time zero. Eight programmable delays, labelled A through H and given in ticks, then place edges relative to that reference.

From the eight edges the block derives several kinds of output:

- four paired pulses, AB, CD, EF and GH, each with its own polarity;
- eight stepped levels that all clear together shortly after the largest delay;
- eight fixed-width strobes, one per channel;
- four OR-combined outputs that carry two, three or four pulses per cycle.

An inhibit input forces the pulse outputs to their inactive level while it is high. A busy flag covers the whole cycle, from the accepted start until the reference falls.

The delays are captured when the start is accepted, so software may load the next set while a cycle runs. The latency, the tail after the largest delay and the strobe width are given in nanoseconds and rounded up to whole ticks.

Top module: `delay_sequencer`

## Requirements
- R1: A start_i high at a rising edge while busy_o is low is accepted, and busy_o is high after that edge. A start_i high while busy_o is high is ignored, and the running cycle continues unchanged.
- R2: t0_o rises exactly 9 clock edges after the accepting edge, which is 85 ns rounded up to ticks. Time zero, written t, counts edges from that rise, with t = 0 at the rise.
- R3: t0_o and busy_o fall together at t = max(delay) + 3, where 3 ticks is 25 ns rounded up. Before that, t0_o stays high for the whole cycle.
- R4: step_o[i] is high for max(delay) + 3 > t >= delay[i] and low otherwise. Channel i (A=0 .. H=7) uses bits dly_i[16*i +: 16].
- R5: Pair p (bit 0 = AB, 1 = CD, 2 = EF, 3 = GH) uses channels 2p and 2p+1. It is active for delay[2p+1] > t >= delay[2p]. It stays inactive for the whole cycle when delay[2p+1] <= delay[2p].
- R6: pair_o[p] equals the active level XOR pol_i[p]. With pol_i[p] = 1 the output idles high and pulses low.
- R7: comb_o[0] = AB|CD, comb_o[1] = EF|GH, comb_o[2] = AB|CD|EF and comb_o[3] = AB|CD|EF|GH, all taken from the non-inverted active levels.
- R8: hv_o[i] is high for delay[i] + 10 > t >= delay[i], which is 100 ns. It is cut short when the cycle ends.
- R9: When inhibit_i is high at an edge, step_o, hv_o and comb_o are low after that edge and every pair_o sits at its inactive level. t0_o and busy_o are unaffected.
- R10: The delays are captured at the accepting edge. Changing dly_i during a cycle has no effect on that cycle.
- R11: After reset, busy_o, t0_o, step_o, hv_o and comb_o are low, and pair_o equals pol_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst | input | 1 | synchronous active-high reset |
| start_i | input | 1 | cycle start strobe |
| dly_i | input | 128 | eight 16-bit delays in ticks, channel i at [16*i +: 16] |
| pol_i | input | 4 | per-pair invert bits |
| inhibit_i | input | 1 | forces pulse outputs inactive |
| busy_o | output | 1 | cycle in progress |
| t0_o | output | 1 | reference output, high during the cycle |
| pair_o | output | 4 | AB, CD, EF, GH paired pulses |
| step_o | output | 8 | per-channel stepped levels |
| hv_o | output | 8 | per-channel fixed 10-tick strobes |
| comb_o | output | 4 | OR-combined multi-pulse outputs |

## Verification
The bench goes after cycles where all delays are zero. In that case a design that mishandles the tail would end the cycle at once or would never assert the steps. Pairs whose second delay equals or precedes the first are tested too: a comparison done with the wrong direction or an off-by-one bound shows up there as a spurious one-tick pulse. Strobes on the channel with the largest delay are checked for being cut off by the cycle end. A design that runs them past the tail leaves hv_o high while busy_o is low.

Starts asserted during a cycle, and delay changes in the middle of a cycle, show whether a design restarts its counter or compares against live inputs; either fault moves every later edge. Inhibit windows and inverted polarity check that the inactive level follows the polarity bit rather than plain zero.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Round a time in ns up to whole clock ticks.
  function automatic int ns_to_ticks(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int N_CH  = 8,
  parameter int DLY_W = 16,
  parameter int CW    = 18,
  parameter int LAT   = 9,
  parameter int TAIL  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [N_CH*DLY_W-1:0]   dly_i,
  output logic                    busy_o,
  output logic                    run_nxt_o,
  output logic [CW-1:0]           cnt_nxt_o,
  output logic [N_CH*DLY_W-1:0]   dly_q_o
);
  logic                  busy_q, busy_n;
  logic [CW-1:0]         cnt_q, cnt_n, end_q;
  logic [DLY_W-1:0]      dmax;
  logic [N_CH*DLY_W-1:0] dly_q;
  logic                  accept;

  assign accept = start_i && !busy_q;

  // Largest programmed delay among the incoming values.
  always_comb begin
    dmax = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (dly_i[i*DLY_W +: DLY_W] > dmax) dmax = dly_i[i*DLY_W +: DLY_W];
    end
  end

  // Value the counter and busy flag take at the coming edge.
  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (busy_q) begin
      cnt_n  = cnt_q + CW'(1);
      busy_n = (cnt_n != end_q);
    end else if (start_i) begin
      cnt_n  = '0;
      busy_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      end_q  <= '0;
      dly_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      if (accept) begin
        dly_q <= dly_i;
        end_q <= CW'(LAT) + CW'(dmax) + CW'(TAIL);
      end
    end
  end

  assign busy_o    = busy_q;
  assign run_nxt_o = busy_n && (cnt_n >= CW'(LAT));
  assign cnt_nxt_o = cnt_n;
  assign dly_q_o   = dly_q;

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (!busy_q || cnt_q == $past(cnt_q) + CW'(1))); // R1
  AST_DLY_HELD: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (!busy_q || dly_q == $past(dly_q))); // R10
endmodule

// File: rtl/seq_chan.sv
module seq_chan #(
  parameter int DLY_W = 16,
  parameter int CW    = 18,
  parameter int LAT   = 9,
  parameter int HV    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             inh_i,
  output logic             ge_o,
  output logic             step_o,
  output logic             hv_o
);
  logic [CW-1:0] t_on;
  logic          hv_w;

  assign t_on = CW'(LAT) + CW'(dly_i);
  assign ge_o = run_i && (cnt_i >= t_on);
  assign hv_w = ge_o && (cnt_i < t_on + CW'(HV));

  always_ff @(posedge clk) begin
    if (rst) begin
      step_o <= 1'b0;
      hv_o   <= 1'b0;
    end else begin
      step_o <= ge_o && !inh_i;
      hv_o   <= hv_w && !inh_i;
    end
  end

  AST_HV_IN_STEP: assert property (@(posedge clk) disable iff (rst)
    hv_o |-> step_o); // R8
endmodule

// File: rtl/seq_pair.sv
module seq_pair #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2*NP-1:0] ge_i,
  input  logic [NP-1:0] pol_i,
  input  logic          inh_i,
  output logic [NP-1:0] act_n_o,
  output logic [NP-1:0] pair_o
);
  generate
    for (genvar p = 0; p < NP; p++) begin : g_pair
      // Active from the first edge until the second edge is reached.
      assign act_n_o[p] = ge_i[2*p] && !ge_i[2*p+1] && !inh_i;
      always_ff @(posedge clk) begin
        if (rst) pair_o[p] <= pol_i[p];
        else     pair_o[p] <= act_n_o[p] ^ pol_i[p];
      end
    end
  endgenerate

  AST_INH_IDLE: assert property (@(posedge clk) disable iff (rst)
    inh_i |=> (pair_o == $past(pol_i))); // R9
endmodule

// File: rtl/seq_comb.sv
module seq_comb #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] act_i,
  output logic [3:0]    comb_o
);
  logic [3:0] comb_n;

  assign comb_n[0] = |act_i[1:0];
  assign comb_n[1] = |act_i[3:2];
  assign comb_n[2] = |act_i[2:0];
  assign comb_n[3] = |act_i[NP-1:0];

  always_ff @(posedge clk) begin
    if (rst) comb_o <= '0;
    else     comb_o <= comb_n;
  end

  AST_COMB_NEST2: assert property (@(posedge clk) disable iff (rst)
    comb_o[0] |-> comb_o[2]); // R7
  AST_COMB_NEST3: assert property (@(posedge clk) disable iff (rst)
    (comb_o[1] || comb_o[2]) |-> comb_o[3]); // R7
endmodule

// File: rtl/delay_sequencer.sv
module delay_sequencer #(
  parameter int N_CH    = 8,
  parameter int DLY_W   = 16,
  parameter int CLK_NS  = 10,
  parameter int LAT_NS  = 85,
  parameter int TAIL_NS = 25,
  parameter int HV_NS   = 100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [N_CH*DLY_W-1:0] dly_i,
  input  logic [N_CH/2-1:0]     pol_i,
  input  logic                  inhibit_i,
  output logic                  busy_o,
  output logic                  t0_o,
  output logic [N_CH/2-1:0]     pair_o,
  output logic [N_CH-1:0]       step_o,
  output logic [N_CH-1:0]       hv_o,
  output logic [3:0]            comb_o
);
  import seq_pkg::*;

  localparam int NP   = N_CH / 2;
  localparam int CW   = DLY_W + 2;
  localparam int LAT  = ns_to_ticks(LAT_NS, CLK_NS);
  localparam int TAIL = ns_to_ticks(TAIL_NS, CLK_NS);
  localparam int HV   = ns_to_ticks(HV_NS, CLK_NS);

  logic                  run_nxt;
  logic [CW-1:0]         cnt_nxt;
  logic [N_CH*DLY_W-1:0] dly_q;
  logic [N_CH-1:0]       ge;
  logic [NP-1:0]         act_n;

  seq_timer #(.N_CH(N_CH), .DLY_W(DLY_W), .CW(CW), .LAT(LAT), .TAIL(TAIL)) u_timer (
    .clk(clk), .rst(rst), .start_i(start_i), .dly_i(dly_i),
    .busy_o(busy_o), .run_nxt_o(run_nxt), .cnt_nxt_o(cnt_nxt), .dly_q_o(dly_q)
  );

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_chan
      seq_chan #(.DLY_W(DLY_W), .CW(CW), .LAT(LAT), .HV(HV)) u_chan (
        .clk(clk), .rst(rst), .run_i(run_nxt), .cnt_i(cnt_nxt),
        .dly_i(dly_q[i*DLY_W +: DLY_W]), .inh_i(inhibit_i),
        .ge_o(ge[i]), .step_o(step_o[i]), .hv_o(hv_o[i])
      );
    end
  endgenerate

  seq_pair #(.NP(NP)) u_pair (
    .clk(clk), .rst(rst), .ge_i(ge), .pol_i(pol_i), .inh_i(inhibit_i),
    .act_n_o(act_n), .pair_o(pair_o)
  );

  seq_comb #(.NP(NP)) u_comb (
    .clk(clk), .rst(rst), .act_i(act_n), .comb_o(comb_o)
  );

  always_ff @(posedge clk) begin
    if (rst) t0_o <= 1'b0;
    else     t0_o <= run_nxt;
  end

  AST_T0_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    t0_o |-> busy_o); // R2
  AST_END_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (!t0_o && step_o == '0 && hv_o == '0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (comb_o == '0 && step_o == '0)); // R4
endmodule

// File: tb/delay_sequencer_test.sv
module delay_sequencer_test;
  localparam int CLK_P = 10;
  localparam int LAT   = 9;
  localparam int TAIL  = 3;
  localparam int HV    = 10;
  localparam int WD    = 150000;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [127:0] dly_i;
  logic [3:0]   pol_i;
  logic         inhibit_i;
  logic         busy_o, t0_o;
  logic [3:0]   pair_o, comb_o;
  logic [7:0]   step_o, hv_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  delay_sequencer uut (
    .clk(clk), .rst(rst), .start_i(start_i), .dly_i(dly_i), .pol_i(pol_i),
    .inhibit_i(inhibit_i), .busy_o(busy_o), .t0_o(t0_o), .pair_o(pair_o),
    .step_o(step_o), .hv_o(hv_o), .comb_o(comb_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected comb bits from active pair levels (R7).
  function automatic logic [3:0] comb_of(input logic [3:0] a);
    return {|a, |a[2:0], |a[3:2], |a[1:0]};
  endfunction

  // mode: 0 no inhibit, 1 random inhibit, 2 inhibit whole cycle, 3 short window
  task automatic run_cycle(input int d[8], input logic [3:0] pol, input int mode, input bit noisy);
    int maxd, endt, r;
    bit inh_e, inw;
    logic [7:0] st_e, hv_e;
    logic [3:0] act_e;
    maxd = 0;
    for (int i = 0; i < 8; i++) begin
      dly_i[i*16 +: 16] = 16'(d[i]);
      if (d[i] > maxd) maxd = d[i];
    end
    endt = LAT + maxd + TAIL;
    pol_i = pol;
    start_i = 1'b1;
    inhibit_i = (mode == 2);
    @(posedge clk);
    for (int j = 0; j <= endt + 1; j++) begin
      @(negedge clk);
      if (j >= 1) begin
        inw = (j >= LAT) && (j < endt);
        r = j - LAT;
        for (int i = 0; i < 8; i++) begin
          st_e[i] = inw && r >= d[i] && !inh_e;
          hv_e[i] = inw && r >= d[i] && r < d[i] + HV && !inh_e;
        end
        for (int p = 0; p < 4; p++)
          act_e[p] = inw && r >= d[2*p] && r < d[2*p+1] && !inh_e;
        chk("R1/R3 busy", 32'(busy_o), 32'(j < endt));
        chk("R2 t0", 32'(t0_o), 32'(inw));
        chk("R4/R9/R10 step", 32'(step_o), 32'(st_e));
        chk("R8 hv", 32'(hv_o), 32'(hv_e));
        chk("R5/R6 pair", 32'(pair_o), 32'(act_e ^ pol));
        chk("R7 comb", 32'(comb_o), 32'(comb_of(act_e)));
      end
      // Drive inputs for the next edge.
      case (mode)
        1: inhibit_i = ($urandom % 8) == 0;
        2: inhibit_i = 1'b1;
        3: inhibit_i = (j >= LAT + 1) && (j < LAT + 4);
        default: inhibit_i = 1'b0;
      endcase
      inh_e = inhibit_i;
      start_i = noisy && (j < endt - 1) && (($urandom % 4) == 0);
      if (noisy) dly_i = {$urandom, $urandom, $urandom, $urandom};
    end
    start_i = 1'b0;
    inhibit_i = 1'b0;
    @(negedge clk);
    chk("R1 idle busy", 32'(busy_o), 32'd0);
    chk("R6 idle pair", 32'(pair_o), 32'(pol));
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int d[8];
    void'($urandom(32'd1234));
    rst = 1'b1; start_i = 1'b0; dly_i = '0; pol_i = 4'b1010; inhibit_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 busy", 32'(busy_o), 32'd0);
    chk("R11 t0", 32'(t0_o), 32'd0);
    chk("R11 step/hv", 32'({step_o, hv_o}), 32'd0);
    chk("R11 comb", 32'(comb_o), 32'd0);
    chk("R11 pair", 32'(pair_o), 32'(pol_i));
    rst = 1'b0;
    @(negedge clk);

    // All delays zero: 3-tick cycle, empty pairs.
    d = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_cycle(d, 4'b0000, 0, 0);
    // Ordered pairs, largest delay on channel D, strobes cut at the end (R8).
    d = '{2, 6, 1, 30, 4, 12, 0, 25};
    run_cycle(d, 4'b0000, 0, 0);
    // Equal and reversed pairs stay inactive (R5), inverted polarity (R6).
    d = '{5, 5, 9, 3, 1, 20, 14, 14};
    run_cycle(d, 4'b1111, 0, 0);
    // Whole-cycle and short-window inhibit (R9).
    d = '{1, 8, 3, 10, 5, 12, 7, 15};
    run_cycle(d, 4'b0101, 2, 0);
    run_cycle(d, 4'b0011, 3, 0);
    // Starts during busy and delay changes mid-cycle (R1, R10).
    run_cycle(d, 4'b0000, 0, 1);

    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 8; i++) d[i] = $urandom % 40;
      run_cycle(d, 4'($urandom), ($urandom % 2), ($urandom % 2) == 1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule